// File: doc/BRIEF.md
# OSD Serial Write Command Decoder

This block sits behind a serial receiver in an on-screen-display controller. It is fed bytes that have already been received, each marked by a valid strobe and a start-of-packet flag. It turns that stream into write commands for a display memory. The memory is laid out as rows and columns and has two byte planes: a character-code plane and an attribute plane. Rows 0 to 10 and columns 0 to 31 can be addressed. Control registers take columns 24 to 31 of rows 0 to 9 and columns 0 to 17 of row 10. The decoder does not treat these locations in any special way.

A packet always opens with a row address byte. After that, the host picks a packet format. In the single-write format each data byte is preceded by a row byte and a column byte. In the same-row format each data byte is preceded by a column byte only. In the burst format one row and one column set a start location and every byte after that is data. The column, and then the row, step forward by themselves after each data byte. The single-write and same-row formats can follow each other freely, and either can enter burst. Only a new packet ends a burst.

Each write appears on the write port in the same cycle as the data byte that causes it. The port carries the row, column, plane and data byte. The memory itself is not part of the block.

Top module: `osd_cmd_decoder`

## Requirements
- R1: While reset is high and on the first cycle after it, the decoder expects a row byte, and its row and column registers are zero. A synchronous reset in the middle of a burst returns it to the row-expected state.
- R2: A row byte has bit 7 = 1. Bit 6 selects the plane (0 = character plane, 1 = attribute plane) and bits 3..0 give the row. A byte with bit 7 = 0 that arrives while a row is expected is ignored: it causes no write and the decoder keeps expecting a row.
- R3: A byte flagged as start-of-packet is always treated as a row byte, whatever state the decoder is in, and never produces a write.
- R4: When an address is expected after a row byte, a byte with bit 7 = 0 is a column byte. Bits 4..0 give the column. Bit 6 = 0 means one data byte follows, and bit 6 = 1 starts a burst. A byte with bit 7 = 1 in this position replaces the row and plane.
- R5: After a single data byte, a byte with bit 7 = 1 is a new row byte (single-write format).
- R6: After a single data byte, a byte with bit 7 = 0 is a column byte. It keeps the current row and plane (same-row format).
- R7: Each data byte gives exactly one write pulse, in the cycle of its valid strobe. The write carries the byte unchanged with the current row, column and plane.
- R8: In a burst the column goes up by one after each data byte. From 31 it wraps to 0 and the row goes up by one. From row 10 the row wraps to 0.
- R9: Once a burst has started, every byte is data, including bytes with bit 7 = 1, until the next start-of-packet.
- R10: A cycle with the valid strobe low produces no write and changes neither the state nor the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte strobe |
| in_sop | input | 1 | Marks the first byte of a packet |
| in_byte | input | 8 | Received byte |
| wr_en | output | 1 | Write pulse, one per data byte |
| wr_row | output | 4 | Row of the write |
| wr_col | output | 5 | Column of the write |
| wr_plane | output | 1 | 0 = character plane, 1 = attribute plane |
| wr_data | output | 8 | Byte to write |

## Verification
The decoder is driven with each packet format on its own and with the permitted switches between them: single-write to same-row, same-row back to single-write, and either one into burst. A wrong choice of next state therefore shows up as a write to the wrong row or column. Bursts are started close to column 31 and at row 10 so that the column wrap and the row wrap are both observed. The bench sends bytes with bit 7 set in the middle of a burst to separate data bytes from address bytes. It also places start-of-packet bytes, bytes with bit 7 clear in the row position, idle gaps and a mid-burst reset to show which stimuli leave the address untouched and which ones restart decoding.

// File: rtl/osd_cmd_pkg.sv
package osd_cmd_pkg;
  // Decoder phase: what the next byte is taken to be.
  typedef enum logic [1:0] {
    ST_ROW   = 2'd0,  // row byte expected
    ST_ADDR  = 2'd1,  // row or column byte expected
    ST_DATA  = 2'd2,  // one data byte expected
    ST_BURST = 2'd3   // data bytes until a new packet
  } dec_state_e;

  // Byte field positions that the phase logic decodes.
  localparam int TAG_BIT = 7;  // 1 = row byte, 0 = column byte
  localparam int SEL_BIT = 6;  // row: plane, column: burst select
endpackage

// File: rtl/osd_byte_fields.sv
module osd_byte_fields #(
  parameter int DATA_W = 8,
  parameter int ROW_W  = 4,
  parameter int COL_W  = 5
) (
  input  logic [DATA_W-1:0] byte_in,
  output logic              is_row,
  output logic              sel,
  output logic [ROW_W-1:0]  row_f,
  output logic [COL_W-1:0]  col_f
);
  import osd_cmd_pkg::*;

  always_comb begin
    is_row = byte_in[TAG_BIT];
    sel    = byte_in[SEL_BIT];
    row_f  = byte_in[ROW_W-1:0];
    col_f  = byte_in[COL_W-1:0];
  end
endmodule

// File: rtl/osd_fmt_fsm.sv
module osd_fmt_fsm (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    valid,
  input  logic                    sop,
  input  logic                    is_row,
  input  logic                    sel,
  output osd_cmd_pkg::dec_state_e st_q,
  output logic                    load_row,
  output logic                    load_col,
  output logic                    advance,
  output logic                    fire
);
  import osd_cmd_pkg::*;

  dec_state_e act_st;
  dec_state_e st_d;

  always_comb begin
    act_st   = sop ? ST_ROW : st_q;
    st_d     = st_q;
    load_row = 1'b0;
    load_col = 1'b0;
    advance  = 1'b0;
    fire     = 1'b0;
    if (valid) begin
      st_d = act_st;
      unique case (act_st)
        ST_ROW: begin
          if (is_row) begin
            load_row = 1'b1;
            st_d     = ST_ADDR;
          end
        end
        ST_ADDR: begin
          if (is_row) begin
            load_row = 1'b1;
          end else begin
            load_col = 1'b1;
            st_d     = sel ? ST_BURST : ST_DATA;
          end
        end
        ST_DATA: begin
          fire = 1'b1;
          st_d = ST_ADDR;
        end
        ST_BURST: begin
          fire    = 1'b1;
          advance = 1'b1;
        end
        default: st_d = ST_ROW;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_ROW;
    else     st_q <= st_d;
  end
endmodule

// File: rtl/osd_addr_track.sv
module osd_addr_track #(
  parameter int ROW_W    = 4,
  parameter int COL_W    = 5,
  parameter int NUM_ROWS = 11,
  parameter int NUM_COLS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_row,
  input  logic [ROW_W-1:0] row_in,
  input  logic             plane_in,
  input  logic             load_col,
  input  logic [COL_W-1:0] col_in,
  input  logic             advance,
  output logic [ROW_W-1:0] row_q,
  output logic [COL_W-1:0] col_q,
  output logic             plane_q
);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(NUM_ROWS - 1);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(NUM_COLS - 1);

  logic [ROW_W-1:0] row_step;
  logic [COL_W-1:0] col_step;
  logic             col_wrap;

  always_comb begin
    col_wrap = (col_q == COL_LAST);
    col_step = col_wrap ? '0 : col_q + 1'b1;
    if (!col_wrap)              row_step = row_q;
    else if (row_q >= ROW_LAST) row_step = '0;
    else                        row_step = row_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q   <= '0;
      col_q   <= '0;
      plane_q <= 1'b0;
    end else if (load_row) begin
      row_q   <= row_in;
      plane_q <= plane_in;
    end else if (load_col) begin
      col_q   <= col_in;
    end else if (advance) begin
      row_q   <= row_step;
      col_q   <= col_step;
    end
  end
endmodule

// File: rtl/osd_cmd_decoder.sv
module osd_cmd_decoder #(
  parameter int DATA_W   = 8,
  parameter int ROW_W    = 4,
  parameter int COL_W    = 5,
  parameter int NUM_ROWS = 11,
  parameter int NUM_COLS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic [DATA_W-1:0] in_byte,
  output logic              wr_en,
  output logic [ROW_W-1:0]  wr_row,
  output logic [COL_W-1:0]  wr_col,
  output logic              wr_plane,
  output logic [DATA_W-1:0] wr_data
);
  import osd_cmd_pkg::*;

  logic             is_row, sel;
  logic [ROW_W-1:0] row_f;
  logic [COL_W-1:0] col_f;
  logic             load_row, load_col, advance, fire;
  dec_state_e       st_q;

  osd_byte_fields #(.DATA_W(DATA_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_fields (
    .byte_in (in_byte),
    .is_row  (is_row),
    .sel     (sel),
    .row_f   (row_f),
    .col_f   (col_f)
  );

  osd_fmt_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .valid    (in_valid),
    .sop      (in_sop),
    .is_row   (is_row),
    .sel      (sel),
    .st_q     (st_q),
    .load_row (load_row),
    .load_col (load_col),
    .advance  (advance),
    .fire     (fire)
  );

  osd_addr_track #(
    .ROW_W(ROW_W), .COL_W(COL_W), .NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS)
  ) u_addr (
    .clk      (clk),
    .rst      (rst),
    .load_row (load_row),
    .row_in   (row_f),
    .plane_in (sel),
    .load_col (load_col),
    .col_in   (col_f),
    .advance  (advance),
    .row_q    (wr_row),
    .col_q    (wr_col),
    .plane_q  (wr_plane)
  );

  // The write leaves in the cycle of the data byte; the address is registered.
  assign wr_en   = fire;
  assign wr_data = in_byte;
endmodule

// File: rtl/osd_cmd_decoder_chk.sv
module osd_cmd_decoder_chk #(
  parameter int DATA_W   = 8,
  parameter int ROW_W    = 4,
  parameter int COL_W    = 5,
  parameter int NUM_COLS = 32
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    in_sop,
  input logic [DATA_W-1:0]       in_byte,
  input logic                    wr_en,
  input logic [ROW_W-1:0]        wr_row,
  input logic [COL_W-1:0]        wr_col,
  input logic                    wr_plane,
  input osd_cmd_pkg::dec_state_e st
);
  import osd_cmd_pkg::*;
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(NUM_COLS - 1);

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (st == ST_ROW && wr_row == '0 && wr_col == '0)); // R1

  AST_IGNORE_NONROW: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_sop && st == ST_ROW && !in_byte[TAG_BIT]) |=> st == ST_ROW); // R2

  AST_SOP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sop) |-> !wr_en); // R3

  AST_SOP_ROW_LOAD: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sop && in_byte[TAG_BIT]) |=>
      (st == ST_ADDR && wr_row == $past(in_byte[ROW_W-1:0]) && wr_plane == $past(in_byte[SEL_BIT]))); // R3

  AST_BURST_COL_STEP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && st == ST_BURST && wr_col != COL_LAST) |=> wr_col == $past(wr_col) + 1'b1); // R8

  AST_BURST_COL_WRAP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && st == ST_BURST && wr_col == COL_LAST) |=> wr_col == '0); // R8

  AST_BURST_STICKY: assert property (@(posedge clk) disable iff (rst)
    (st == ST_BURST && !(in_valid && in_sop)) |=> st == ST_BURST); // R9

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> !wr_en); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(st) && $stable(wr_row) && $stable(wr_col) && $stable(wr_plane))); // R10
endmodule

bind osd_cmd_decoder osd_cmd_decoder_chk #(
  .DATA_W(DATA_W), .ROW_W(ROW_W), .COL_W(COL_W), .NUM_COLS(NUM_COLS)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_sop   (in_sop),
  .in_byte  (in_byte),
  .wr_en    (wr_en),
  .wr_row   (wr_row),
  .wr_col   (wr_col),
  .wr_plane (wr_plane),
  .st       (st_q)
);

// File: tb/tb_osd_cmd_decoder.sv
`timescale 1ns/1ps
module tb_osd_cmd_decoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_sop = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       wr_en;
  logic [3:0] wr_row;
  logic [4:0] wr_col;
  logic       wr_plane;
  logic [7:0] wr_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  osd_cmd_decoder dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_byte(in_byte),
    .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col), .wr_plane(wr_plane), .wr_data(wr_data)
  );

  typedef struct packed {
    logic       sop;
    logic [7:0] b;
    logic       we;
    logic [3:0] row;
    logic [4:0] col;
    logic       pl;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h83, 1'b0, 4'd0,  5'd0,  1'b0}, // R3 row 3, char plane
    '{1'b0, 8'h05, 1'b0, 4'd0,  5'd0,  1'b0}, // R4 column 5 single
    '{1'b0, 8'hA1, 1'b1, 4'd3,  5'd5,  1'b0}, // R7 data
    '{1'b0, 8'h07, 1'b0, 4'd0,  5'd0,  1'b0}, // R6 same-row column 7
    '{1'b0, 8'h42, 1'b1, 4'd3,  5'd7,  1'b0}, // R6 data keeps row
    '{1'b0, 8'hC9, 1'b0, 4'd0,  5'd0,  1'b0}, // R5 new row 9, attr plane
    '{1'b0, 8'h1F, 1'b0, 4'd0,  5'd0,  1'b0}, // R4 column 31
    '{1'b0, 8'h55, 1'b1, 4'd9,  5'd31, 1'b1}, // R5 data
    '{1'b0, 8'h5E, 1'b0, 4'd0,  5'd0,  1'b0}, // R4 burst at column 30
    '{1'b0, 8'h11, 1'b1, 4'd9,  5'd30, 1'b1}, // R8
    '{1'b0, 8'h22, 1'b1, 4'd9,  5'd31, 1'b1}, // R8
    '{1'b0, 8'h8A, 1'b1, 4'd10, 5'd0,  1'b1}, // R9 bit7 byte is data, R8 wrap
    '{1'b0, 8'h05, 1'b1, 4'd10, 5'd1,  1'b1}, // R8
    '{1'b1, 8'h0A, 1'b0, 4'd0,  5'd0,  1'b0}, // R3 sop bit7 clear: ignored
    '{1'b0, 8'h33, 1'b0, 4'd0,  5'd0,  1'b0}, // R2 ignored in row state
    '{1'b0, 8'h8A, 1'b0, 4'd0,  5'd0,  1'b0}, // R2 row 10
    '{1'b0, 8'h84, 1'b0, 4'd0,  5'd0,  1'b0}, // R4 row reload to 4
    '{1'b0, 8'h5F, 1'b0, 4'd0,  5'd0,  1'b0}, // R4 burst at column 31
    '{1'b0, 8'h77, 1'b1, 4'd4,  5'd31, 1'b0}, // R8
    '{1'b0, 8'h78, 1'b1, 4'd5,  5'd0,  1'b0}  // R8 row step
  };

  // Drive one byte at the falling edge and check the same-cycle write.
  task automatic send(input logic sop, input logic [7:0] b, input logic we,
                      input logic [3:0] row, input logic [4:0] col, input logic pl,
                      input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_sop   = sop;
    in_byte  = b;
    #1;
    checks++;
    if (wr_en !== we) begin
      failures++;
      $display("FAIL %s byte %h: wr_en=%b expected %b", tag, b, wr_en, we);
    end else if (we && (wr_row !== row || wr_col !== col || wr_plane !== pl || wr_data !== b)) begin
      failures++;
      $display("FAIL %s byte %h: row=%0d col=%0d plane=%b data=%h expected row=%0d col=%0d plane=%b data=%h",
               tag, b, wr_row, wr_col, wr_plane, wr_data, row, col, pl, b);
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_sop   = 1'b0;
      in_byte  = 8'hFF;
      #1;
      checks++;
      if (wr_en !== 1'b0) begin
        failures++;
        $display("FAIL %s idle: wr_en=%b expected 0", tag, wr_en);
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    // R1: reset state seen at the ports
    @(negedge clk);
    checks++;
    if (wr_en !== 1'b0 || wr_row !== 4'd0 || wr_col !== 5'd0) begin
      failures++;
      $display("FAIL R1 reset: wr_en=%b row=%0d col=%0d expected 0 0 0", wr_en, wr_row, wr_col);
    end
    rst = 1'b0;

    for (int i = 0; i < NV; i++)
      send(VECS[i].sop, VECS[i].b, VECS[i].we, VECS[i].row, VECS[i].col, VECS[i].pl, "R7 table");

    // R8: row wraps from 10 to 0
    send(1'b1, 8'h8A, 1'b0, 4'd0, 5'd0, 1'b0, "R8");
    send(1'b0, 8'h5F, 1'b0, 4'd0, 5'd0, 1'b0, "R8");
    send(1'b0, 8'hE1, 1'b1, 4'd10, 5'd31, 1'b0, "R8");
    send(1'b0, 8'hE2, 1'b1, 4'd0, 5'd0, 1'b0, "R8 row wrap");

    // R3: sop while a data byte is expected aborts it
    send(1'b1, 8'h82, 1'b0, 4'd0, 5'd0, 1'b0, "R3");
    send(1'b0, 8'h03, 1'b0, 4'd0, 5'd0, 1'b0, "R3");
    send(1'b1, 8'hC1, 1'b0, 4'd0, 5'd0, 1'b0, "R3 sop in data phase");
    send(1'b0, 8'h04, 1'b0, 4'd0, 5'd0, 1'b0, "R3");
    send(1'b0, 8'hEE, 1'b1, 4'd1, 5'd4, 1'b1, "R3 new row used");

    // R10: idle gaps inside a burst do not move the address
    send(1'b1, 8'h86, 1'b0, 4'd0, 5'd0, 1'b0, "R10");
    send(1'b0, 8'h4C, 1'b0, 4'd0, 5'd0, 1'b0, "R10");
    send(1'b0, 8'h10, 1'b1, 4'd6, 5'd12, 1'b0, "R10");
    idle(4, "R10");
    send(1'b0, 8'h20, 1'b1, 4'd6, 5'd13, 1'b0, "R10 after gap");

    // R1: reset in the middle of a burst
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    send(1'b0, 8'h05, 1'b0, 4'd0, 5'd0, 1'b0, "R1 row state after reset");
    send(1'b0, 8'h85, 1'b0, 4'd0, 5'd0, 1'b0, "R1");
    send(1'b0, 8'h02, 1'b0, 4'd0, 5'd0, 1'b0, "R1");
    send(1'b0, 8'h99, 1'b1, 4'd5, 5'd2, 1'b0, "R1 single write");
    idle(2, "R10");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule